// File: doc/BRIEF.md
# Serial-EEPROM Boot Configuration Sequencer

This block runs once after reset, and again on request, to pull device settings out of a byte-wide serial EEPROM. It asks an external EEPROM controller for one byte at a time. The image starts with a header byte. Behind the header come three sections: a station MAC address, a 32-bit strap configuration word, and a list of register-write bursts. The strap section and the burst section each have their own guard byte. The MAC address and the strap word are held on output ports. Each burst word goes out as one transfer on a valid/ready register write port.

Four events start a load. The first is `rst_n` going low and then high, which covers the pin reset. The second is a pulse on `por` (power-on reset). The third is a pulse on `soft_rst` (software digital reset). The fourth is a pulse on `reload`, but only while the block is idle. While a load runs, `busy` is high and `ready` is low, and the host must not write to the device. The EEPROM side uses a request/acknowledge pair and has a cycle timeout.

The write port follows normal valid/ready rules. Once `wr_valid` is high, it stays high and `wr_addr`/`wr_data` stay unchanged until a cycle in which `wr_ready` is also high. That cycle is the transfer. The sink may hold `wr_ready` low for as long as it likes, and the loader simply waits.

Top module: `eeldr_top`

## Requirements
- R1: After `rst_n` rises, or on a start event, `busy`=1 and `ready`=0 until the load ends. After that, `busy`=0 and `ready`=1. While idle, no read request and no write is issued.
- R2: If byte 0 is not A5h, only byte 0 is read. Nothing is loaded (`mac_valid`=0, `strap_valid`=0, no writes) and the load ends.
- R3: Bytes 1..6 form `mac_addr`, least significant byte first: byte 1 goes to bits [7:0] and byte 6 to bits [47:40]. `mac_valid` is set once byte 6 has been read.
- R4: Byte 7 guards the strap word. If byte 7 is A5h, bytes 8..11 form `strap_cfg` least significant byte first and `strap_valid`=1. If not, bytes 8..11 are never read, and loading continues at byte 12.
- R5: Byte 12 guards the bursts. If it is not A5h, the load ends with no writes. If it is A5h, byte 13 gives the burst count and burst data starts at byte 14.
- R6: Each burst is laid out as: start register address (2 bytes, low byte first), then a word count N (1 byte), then N 32-bit words (each low byte first). The words are written to consecutive register addresses, starting at the start address.
- R7: A burst count of 0 ends the load right after byte 13, with no writes. A burst with N=0 writes nothing, and the next burst header follows directly.
- R8: If the next read would address byte EE_SIZE or above, no request is issued. `err` is set and the load ends.
- R9: If `rd_ack` does not arrive within TMO_CYC cycles of a request, the request is dropped, `err` is set and the load ends.
- R10: A `reload` pulse while `busy`=1 has no effect. A `reload` pulse while idle starts a fresh load.
- R11: A `por` or `soft_rst` pulse at any time aborts the current load. It drops any open request or write, and the load restarts from byte 0.
- R12: `rd_req` and `rd_addr` hold until `rd_ack` arrives. `wr_valid`, `wr_addr` and `wr_data` hold until `wr_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low pin reset; a load starts once it is released |
| por | input | 1 | Power-on reset pulse; restarts the load |
| soft_rst | input | 1 | Software digital-reset pulse; restarts the load |
| reload | input | 1 | Reload request; honoured only while idle |
| rd_req | output | 1 | EEPROM byte read request |
| rd_addr | output | AW = log2(EE_SIZE) | EEPROM byte address |
| rd_ack | input | 1 | Read acknowledge, one cycle, with data |
| rd_data | input | 8 | Read data, valid with rd_ack |
| wr_valid | output | 1 | Register write valid |
| wr_ready | input | 1 | Register write ready (back-pressure) |
| wr_addr | output | 16 | Register word address |
| wr_data | output | 32 | Register write data |
| mac_addr | output | 48 | Loaded MAC address |
| mac_valid | output | 1 | MAC address loaded by this run |
| strap_cfg | output | 32 | Loaded strap configuration word |
| strap_valid | output | 1 | Strap word loaded by this run |
| busy | output | 1 | Load in progress |
| ready | output | 1 | Device ready for host access |
| err | output | 1 | Last load ended on overrun or timeout |

## Verification
A byte pointer that drifts shows up on `rd_addr` at the very next request. A bench that logs every requested address catches it within one read, including any read of a skipped strap section. A bad parse state, such as the wrong burst count or a wrong word count, shows up as extra, missing or misaddressed transfers on the write port, or as `busy` never falling. A broken restart or reload gate shows up as a load that does not start again at byte 0, or as a total read count that does not match a single pass.

// File: rtl/eeldr_pkg.sv
package eeldr_pkg;
  localparam logic [7:0] FLAG_OK   = 8'hA5;
  localparam int         REG_AW    = 16;
  localparam int         REG_DW    = 32;
  localparam int         MAC_W     = 48;
  localparam int         BFLAG_POS = 12;

  typedef enum logic [3:0] {
    ST_IDLE, ST_VFLAG, ST_MAC, ST_SFLAG, ST_STRAP,
    ST_BFLAG, ST_NBURST, ST_BADDR, ST_BWCNT, ST_BDATA, ST_WRITE
  } ldr_state_t;
endpackage

// File: rtl/eeldr_rdport.sv
module eeldr_rdport #(
  parameter int AW      = 11,
  parameter int TMO_CYC = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          go,
  input  logic [AW-1:0] go_addr,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  output logic          done,
  output logic          tmo
);
  localparam int CW = $clog2(TMO_CYC + 1);
  logic [CW-1:0] wait_q;

  assign done = rd_req & rd_ack;
  assign tmo  = rd_req & ~rd_ack & (wait_q == CW'(TMO_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_req  <= 1'b0;
      rd_addr <= '0;
      wait_q  <= '0;
    end else if (abort) begin
      rd_req <= 1'b0;
      wait_q <= '0;
    end else if (go) begin
      rd_req  <= 1'b1;
      rd_addr <= go_addr;
      wait_q  <= '0;
    end else if (rd_req) begin
      if (rd_ack || tmo) rd_req <= 1'b0;
      else               wait_q <= wait_q + 1'b1;
    end
  end
endmodule

// File: rtl/eeldr_wrport.sv
module eeldr_wrport #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          push,
  input  logic [AW-1:0] p_addr,
  input  logic [DW-1:0] p_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          fire
);
  assign fire = wr_valid & wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (abort) begin
      wr_valid <= 1'b0;
    end else if (push) begin
      wr_valid <= 1'b1;
      wr_addr  <= p_addr;
      wr_data  <= p_data;
    end else if (fire) begin
      wr_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/eeldr_shreg.sv
module eeldr_shreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [7:0]   din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (en)  q <= {din, q[W-1:8]};
  end
endmodule

// File: rtl/eeldr_top.sv
module eeldr_top
  import eeldr_pkg::*;
#(
  parameter int EE_SIZE = 2048,
  parameter int TMO_CYC = 256,
  localparam int AW = $clog2(EE_SIZE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por,
  input  logic              soft_rst,
  input  logic              reload,
  output logic              rd_req,
  output logic [AW-1:0]     rd_addr,
  input  logic              rd_ack,
  input  logic [7:0]        rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [REG_AW-1:0] wr_addr,
  output logic [REG_DW-1:0] wr_data,
  output logic [MAC_W-1:0]  mac_addr,
  output logic              mac_valid,
  output logic [REG_DW-1:0] strap_cfg,
  output logic              strap_valid,
  output logic              busy,
  output logic              ready,
  output logic              err
);
  localparam int PW = AW + 1;

  ldr_state_t        state;
  logic [PW-1:0]     ptr;
  logic              pend;
  logic [2:0]        idx;
  logic [7:0]        nb_left;
  logic [7:0]        wc_left;
  logic [REG_AW-1:0] baddr;
  logic [REG_DW-1:0] word_q;

  logic restart, fetch_st, over, go, rd_done, rd_tmo, push, wr_fire;
  logic mac_sh, word_sh;
  logic [REG_DW-1:0] word_nx;

  assign restart  = por | soft_rst | (reload & ~busy);
  assign fetch_st = (state != ST_IDLE) && (state != ST_WRITE);
  assign over     = (ptr >= PW'(EE_SIZE));
  assign go       = fetch_st & ~pend & ~over & ~restart;
  assign word_nx  = {rd_data, word_q[REG_DW-1:8]};
  assign mac_sh   = rd_done & (state == ST_MAC);
  assign word_sh  = rd_done & ((state == ST_STRAP) || (state == ST_BDATA));
  assign push     = rd_done & (state == ST_BDATA) & (idx == 3'd3) & ~restart;

  eeldr_rdport #(.AW(AW), .TMO_CYC(TMO_CYC)) u_rd (
    .clk(clk), .rst_n(rst_n), .abort(restart), .go(go),
    .go_addr(ptr[AW-1:0]), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .done(rd_done), .tmo(rd_tmo)
  );

  eeldr_wrport #(.AW(REG_AW), .DW(REG_DW)) u_wr (
    .clk(clk), .rst_n(rst_n), .abort(restart), .push(push),
    .p_addr(baddr), .p_data(word_nx), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .fire(wr_fire)
  );

  eeldr_shreg #(.W(MAC_W)) u_mac (
    .clk(clk), .rst_n(rst_n), .clr(restart), .en(mac_sh),
    .din(rd_data), .q(mac_addr)
  );

  eeldr_shreg #(.W(REG_DW)) u_word (
    .clk(clk), .rst_n(rst_n), .clr(restart), .en(word_sh),
    .din(rd_data), .q(word_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_VFLAG; ptr <= '0; pend <= 1'b0; idx <= '0;
      nb_left <= '0; wc_left <= '0; baddr <= '0;
      busy <= 1'b1; ready <= 1'b0; err <= 1'b0;
      mac_valid <= 1'b0; strap_valid <= 1'b0; strap_cfg <= '0;
    end else if (restart) begin
      state <= ST_VFLAG; ptr <= '0; pend <= 1'b0; idx <= '0;
      nb_left <= '0; wc_left <= '0; baddr <= '0;
      busy <= 1'b1; ready <= 1'b0; err <= 1'b0;
      mac_valid <= 1'b0; strap_valid <= 1'b0; strap_cfg <= '0;
    end else if (fetch_st) begin
      if (!pend) begin
        if (over) begin
          err <= 1'b1; state <= ST_IDLE; busy <= 1'b0; ready <= 1'b1;
        end else begin
          pend <= 1'b1;
        end
      end else if (rd_tmo) begin
        err <= 1'b1; pend <= 1'b0;
        state <= ST_IDLE; busy <= 1'b0; ready <= 1'b1;
      end else if (rd_done) begin
        pend <= 1'b0;
        ptr  <= ptr + 1'b1;
        case (state)
          ST_VFLAG: begin
            if (rd_data == FLAG_OK) begin
              state <= ST_MAC; idx <= '0;
            end else begin
              state <= ST_IDLE; busy <= 1'b0; ready <= 1'b1;
            end
          end
          ST_MAC: begin
            if (idx == 3'd5) begin
              mac_valid <= 1'b1; state <= ST_SFLAG;
            end else idx <= idx + 1'b1;
          end
          ST_SFLAG: begin
            if (rd_data == FLAG_OK) begin
              state <= ST_STRAP; idx <= '0;
            end else begin
              state <= ST_BFLAG; ptr <= PW'(BFLAG_POS);
            end
          end
          ST_STRAP: begin
            if (idx == 3'd3) begin
              strap_cfg <= word_nx; strap_valid <= 1'b1; state <= ST_BFLAG;
            end else idx <= idx + 1'b1;
          end
          ST_BFLAG: begin
            if (rd_data == FLAG_OK) state <= ST_NBURST;
            else begin
              state <= ST_IDLE; busy <= 1'b0; ready <= 1'b1;
            end
          end
          ST_NBURST: begin
            nb_left <= rd_data;
            if (rd_data == 8'd0) begin
              state <= ST_IDLE; busy <= 1'b0; ready <= 1'b1;
            end else begin
              state <= ST_BADDR; idx <= '0;
            end
          end
          ST_BADDR: begin
            if (idx == 3'd0) begin
              baddr[7:0] <= rd_data; idx <= 3'd1;
            end else begin
              baddr[REG_AW-1:8] <= rd_data; state <= ST_BWCNT;
            end
          end
          ST_BWCNT: begin
            wc_left <= rd_data;
            idx     <= '0;
            if (rd_data != 8'd0) state <= ST_BDATA;
            else if (nb_left == 8'd1) begin
              state <= ST_IDLE; busy <= 1'b0; ready <= 1'b1;
            end else begin
              nb_left <= nb_left - 1'b1; state <= ST_BADDR;
            end
          end
          ST_BDATA: begin
            if (idx == 3'd3) state <= ST_WRITE;
            else idx <= idx + 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end else if (state == ST_WRITE && wr_fire) begin
      baddr <= baddr + 1'b1;
      idx   <= '0;
      if (wc_left != 8'd1) begin
        wc_left <= wc_left - 1'b1; state <= ST_BDATA;
      end else if (nb_left == 8'd1) begin
        state <= ST_IDLE; busy <= 1'b0; ready <= 1'b1;
      end else begin
        nb_left <= nb_left - 1'b1; state <= ST_BADDR;
      end
    end
  end
endmodule

// File: rtl/eeldr_chk.sv
module eeldr_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          por,
  input logic          soft_rst,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          rd_ack,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [15:0]   wr_addr,
  input logic [31:0]   wr_data,
  input logic          busy,
  input logic          ready,
  input logic          err
);
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack && !por && !soft_rst |=> (rd_req && $stable(rd_addr)) || err); // R12
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready && !por && !soft_rst |=>
      wr_valid && $stable(wr_addr) && $stable(wr_data)); // R12
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req && !wr_valid); // R1
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ready); // R1
  AST_RESTART_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    por || soft_rst |=> busy && !ready && !rd_req && !wr_valid && !err); // R11
  AST_ERR_ENDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy && ready); // R8
endmodule

bind eeldr_top eeldr_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .por(por), .soft_rst(soft_rst),
  .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .wr_data(wr_data), .busy(busy), .ready(ready), .err(err)
);

// File: tb/eeldr_top_bench.sv
module eeldr_top_bench;
  localparam int EE = 256;
  localparam int TMO = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0, por = 1'b0, soft_rst = 1'b0, reload = 1'b0;
  logic rd_req, rd_ack, wr_valid, wr_ready;
  logic [7:0]  rd_addr, rd_data;
  logic [15:0] wr_addr;
  logic [31:0] wr_data, strap_cfg;
  logic [47:0] mac_addr;
  logic mac_valid, strap_valid, busy, ready, err;

  always #10 clk = ~clk;

  eeldr_top #(.EE_SIZE(EE), .TMO_CYC(TMO)) u_eeldr_top (
    .clk(clk), .rst_n(rst_n), .por(por), .soft_rst(soft_rst), .reload(reload),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .mac_addr(mac_addr), .mac_valid(mac_valid), .strap_cfg(strap_cfg),
    .strap_valid(strap_valid), .busy(busy), .ready(ready), .err(err)
  );

  logic [7:0]  mem [EE];
  logic [15:0] wa [64];
  logic [31:0] wd [64];
  int  rd_n, wr_n, strap_hits, hold_bad, lat, lat_cnt;
  logic [7:0] rd_first;
  bit  mute, stall;
  int  tests = 0, fails = 0;
  logic [3:0] ph = '0;
  logic pv = 1'b0, pr = 1'b0;
  logic [15:0] pa = '0;
  logic [31:0] pd = '0;

  // EEPROM controller and register sink models, driven at the falling edge
  initial begin
    rd_ack = 1'b0; rd_data = '0; wr_ready = 1'b0; lat_cnt = 0;
    forever begin
      @(negedge clk);
      if (rd_ack) rd_ack = 1'b0;
      else if (rd_req && !mute) begin
        if (lat_cnt >= lat) begin
          rd_ack = 1'b1; rd_data = mem[rd_addr]; lat_cnt = 0;
          if (rd_n == 0) rd_first = rd_addr;
          if (rd_addr >= 8 && rd_addr <= 11) strap_hits++;
          rd_n++;
        end else lat_cnt++;
      end else lat_cnt = 0;
      if (pv && !pr && (!wr_valid || wr_addr != pa || wr_data != pd)) hold_bad++;
      ph = ph + 1'b1;
      wr_ready = stall ? ph[1] : 1'b1;
      if (wr_valid && wr_ready) begin
        if (wr_n < 64) begin wa[wr_n] = wr_addr; wd[wr_n] = wr_data; end
        wr_n++;
      end
      pv = wr_valid; pr = wr_ready; pa = wr_addr; pd = wr_data;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic clear_logs();
    rd_n = 0; wr_n = 0; strap_hits = 0; hold_bad = 0; rd_first = 8'hFF;
  endtask

  task automatic img_full();
    for (int i = 0; i < EE; i++) mem[i] = 8'hFF;
    mem[0] = 8'hA5;
    mem[1] = 8'h11; mem[2] = 8'h22; mem[3] = 8'h33;
    mem[4] = 8'h44; mem[5] = 8'h55; mem[6] = 8'h66;
    mem[7] = 8'hA5;
    mem[8] = 8'h78; mem[9] = 8'h56; mem[10] = 8'h34; mem[11] = 8'h12;
    mem[12] = 8'hA5; mem[13] = 8'h02;
    mem[14] = 8'h00; mem[15] = 8'h01; mem[16] = 8'h02;
    mem[17] = 8'hD0; mem[18] = 8'hC0; mem[19] = 8'hB0; mem[20] = 8'hA0;
    mem[21] = 8'h04; mem[22] = 8'h03; mem[23] = 8'h02; mem[24] = 8'h01;
    mem[25] = 8'h00; mem[26] = 8'h02; mem[27] = 8'h01;
    mem[28] = 8'hEF; mem[29] = 8'hBE; mem[30] = 8'hAD; mem[31] = 8'hDE;
  endtask

  task automatic wait_done();
    int n = 0;
    @(negedge clk);
    while (!ready && n < 6000) begin @(negedge clk); n++; end
    chk(ready && !busy, "R1 load ends", {ready, busy}, 2'b10);
  endtask

  task automatic do_reload();
    @(negedge clk); reload = 1'b1;
    @(negedge clk); reload = 1'b0;
    chk(busy && !ready, "R1 busy on start", {busy, ready}, 2'b10);
  endtask

  task automatic expect_full(input string tag);
    chk(mac_valid && mac_addr == 48'h665544332211, {tag, " R3 mac"}, mac_addr, 48'h665544332211);
    chk(strap_valid && strap_cfg == 32'h12345678, {tag, " R4 strap"}, strap_cfg, 32'h12345678);
    chk(wr_n == 3, {tag, " R6 write count"}, wr_n, 3);
    chk(wa[0] == 16'h0100 && wd[0] == 32'hA0B0C0D0, {tag, " R6 word0"}, {wa[0], wd[0]}, {16'h0100, 32'hA0B0C0D0});
    chk(wa[1] == 16'h0101 && wd[1] == 32'h01020304, {tag, " R6 word1"}, {wa[1], wd[1]}, {16'h0101, 32'h01020304});
    chk(wa[2] == 16'h0200 && wd[2] == 32'hDEADBEEF, {tag, " R6 word2"}, {wa[2], wd[2]}, {16'h0200, 32'hDEADBEEF});
    chk(rd_n == 32 && !err, {tag, " R5 reads"}, rd_n, 32);
  endtask

  task automatic t_reset_full();
    img_full(); clear_logs(); lat = 1; stall = 1'b1; mute = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy && !ready, "R1 held in reset", {busy, ready}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy && !ready, "R1 after reset", {busy, ready}, 2'b10);
    wait_done();
    expect_full("full");
    chk(hold_bad == 0, "R12 write hold", hold_bad, 0);
    repeat (5) @(negedge clk);
    chk(!rd_req && !wr_valid && rd_n == 32, "R1 quiet idle", rd_n, 32);
  endtask

  task automatic t_bad_header();
    img_full(); mem[0] = 8'h5A; clear_logs(); stall = 1'b0;
    do_reload(); wait_done();
    chk(!mac_valid && !strap_valid && wr_n == 0, "R2 nothing loaded", {mac_valid, strap_valid}, 0);
    chk(rd_n == 1, "R2 single read", rd_n, 1);
  endtask

  task automatic t_bad_strap();
    img_full(); mem[7] = 8'h00; clear_logs();
    do_reload(); wait_done();
    chk(!strap_valid && mac_valid, "R4 strap skipped", strap_valid, 0);
    chk(strap_hits == 0 && rd_n == 28, "R4 strap bytes unread", rd_n, 28);
    chk(wr_n == 3 && wd[2] == 32'hDEADBEEF, "R4 bursts kept", wr_n, 3);
  endtask

  task automatic t_bad_burst();
    img_full(); mem[12] = 8'h00; clear_logs();
    do_reload(); wait_done();
    chk(wr_n == 0 && rd_n == 13 && strap_valid, "R5 bursts skipped", {wr_n, rd_n}, {32'd0, 32'd13});
  endtask

  task automatic t_zero_counts();
    img_full(); mem[13] = 8'h00; clear_logs();
    do_reload(); wait_done();
    chk(wr_n == 0 && rd_n == 14, "R7 zero bursts", {wr_n, rd_n}, {32'd0, 32'd14});
    img_full();
    mem[14] = 8'h00; mem[15] = 8'h01; mem[16] = 8'h00;
    mem[17] = 8'h00; mem[18] = 8'h03; mem[19] = 8'h01;
    mem[20] = 8'h0D; mem[21] = 8'hF0; mem[22] = 8'hAD; mem[23] = 8'h0B;
    clear_logs(); stall = 1'b1;
    do_reload(); wait_done();
    chk(wr_n == 1 && wa[0] == 16'h0300 && wd[0] == 32'h0BADF00D, "R7 empty burst",
        {wa[0], wd[0]}, {16'h0300, 32'h0BADF00D});
    chk(rd_n == 24, "R7 read count", rd_n, 24);
  endtask

  task automatic t_overrun();
    img_full(); mem[13] = 8'h01; mem[14] = 8'h00; mem[15] = 8'h03; mem[16] = 8'hFF;
    clear_logs(); stall = 1'b0; lat = 0;
    do_reload(); wait_done();
    chk(err, "R8 overrun error", err, 1);
    chk(rd_n == EE, "R8 reads stop at end", rd_n, EE);
    chk(wr_n == 59 && wa[58] == 16'h033A, "R8 partial writes", {wr_n, wa[58]}, {32'd59, 16'h033A});
  endtask

  task automatic t_timeout();
    img_full(); clear_logs(); mute = 1'b1;
    do_reload(); wait_done();
    chk(err && rd_n == 0 && !mac_valid, "R9 timeout", err, 1);
    mute = 1'b0; lat = 1;
    do_reload(); wait_done();
    chk(!err, "R9 error cleared by new load", err, 0);
  endtask

  task automatic t_reload_busy();
    img_full(); clear_logs(); lat = 3;
    do_reload();
    repeat (20) @(negedge clk);
    reload = 1'b1; @(negedge clk); reload = 1'b0;
    wait_done();
    chk(rd_n == 32 && rd_first == 8'd0, "R10 reload ignored while busy", rd_n, 32);
    expect_full("reload");
  endtask

  task automatic t_abort(input bit use_soft);
    img_full(); clear_logs(); lat = 2; stall = 1'b0;
    do_reload();
    repeat (40) @(negedge clk);
    if (use_soft) soft_rst = 1'b1; else por = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0; por = 1'b0;
    chk(busy && !mac_valid, "R11 restart state", {busy, mac_valid}, 2'b10);
    clear_logs();
    wait_done();
    chk(rd_first == 8'd0, "R11 restart from byte 0", rd_first, 0);
    expect_full(use_soft ? "soft" : "por");
  endtask

  initial begin
    #(20 * 190000);
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    t_reset_full();
    t_bad_header();
    t_bad_strap();
    t_bad_burst();
    t_zero_counts();
    t_overrun();
    t_timeout();
    t_reload_busy();
    t_abort(1'b0);
    t_abort(1'b1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule